// File: doc/BRIEF.md
# Two-Class Inter-Core Interrupt Controller

This block lets any of `NCORE` cores post an interrupt request to any core, including itself. Each core owns a send port carrying a destination core number, an 8-bit vector and a class bit (high or low). Posting is synchronous: in the same cycle that a core raises `snd_valid`, the controller answers with exactly one of accepted, busy or rejected. A core that gets busy keeps its request up and tries again. A rejected request is dropped.

All senders share a single request path. A round-robin arbiter grants it to at most one sender per cycle. Each recipient holds two stores. The first is a one-entry urgent slot for high-class requests. The second is a first-in, first-out queue of `LQ_DEPTH` entries for low-class requests. A recipient sees its requests asynchronously, through an interrupt line and the vector currently on offer. An urgent entry is always offered before the head of the queue. The recipient's acknowledge retires whatever entry is on offer.

Only vectors in the window 251 to 255 are treated as inter-core requests. A request with any other vector is refused at the sender side.

Top module: `ipi_ctrl`

## Requirements
- R1: In every cycle in which `snd_valid[i]` is high, exactly one of `snd_accept[i]`, `snd_busy[i]` and `snd_reject[i]` is high in that same cycle. All three are low while `snd_valid[i]` is low.
- R2: A request is rejected, and nothing is delivered, if its vector lies outside 251..255 or its destination is `NCORE` or above.
- R3: An accepted high-class request (`snd_hi`=1) to a recipient with an empty urgent slot makes `irq[d]` high from the next cycle, with `irq_vec` showing the request's vector.
- R4: A high-class request to a recipient whose urgent slot is occupied gets busy, and the entry already in the slot is kept unchanged.
- R5: A low-class request (`snd_hi`=0) is queued at its recipient while fewer than `LQ_DEPTH` (default 4) entries wait there. When the queue is full, the request gets busy.
- R6: Queued low-class requests are offered one at a time, in arrival order. Each acknowledge advances to the next entry.
- R7: While the urgent slot is occupied, its vector is offered ahead of any queued low-class entry, even one that arrived earlier.
- R8: `irq_ack[d]` retires the entry currently offered. `irq[d]` stays high until acknowledged, and falls once nothing is pending. While `irq[d]` is low, `irq_vec` reads 0.
- R9: At most one sender is accepted per cycle. The shared path goes to the first eligible sender at or after the position that follows the previous grant (position 0 after reset). Every other eligible sender gets busy.
- R10: After reset all `irq` lines are low, all `irq_vec` fields are 0 and no request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snd_valid | input | NCORE | Per-sender request strobe |
| snd_dest | input | NCORE*IDW | Per-sender destination core number, sender i at bits [i*IDW +: IDW] |
| snd_vec | input | NCORE*8 | Per-sender vector, sender i at bits [i*8 +: 8] |
| snd_hi | input | NCORE | Per-sender class: 1 high, 0 low |
| snd_accept | output | NCORE | Request taken this cycle |
| snd_busy | output | NCORE | Request well-formed but not taken; retry |
| snd_reject | output | NCORE | Request malformed; dropped |
| irq | output | NCORE | Per-recipient interrupt line |
| irq_vec | output | NCORE*8 | Per-recipient offered vector, recipient d at bits [d*8 +: 8] |
| irq_ack | input | NCORE | Per-recipient acknowledge of the offered entry |

## Verification
A vector table sends single requests from different senders to one recipient. It mixes the two classes with in-window and out-of-window vectors. This tells accept apart from busy and from reject. It also tells a full urgent slot apart from a full queue. Draining that recipient by acknowledges then shows the offer order: the urgent entry first, the queued entries in arrival order, and the line falling at the end. A second pattern raises every sender at once toward the same recipient. The expected winner rotates one position per cycle, which tells round-robin from a fixed priority, and the final all-busy cycle shows the queue limit under contention.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam int VEC_W     = 8;
   localparam int IPI_VEC_LO = 251;
   localparam int IPI_VEC_HI = 255;

   function automatic logic vec_in_window(input logic [VEC_W-1:0] v,
                                          input int lo, input int hi);
      return (int'(v) >= lo) && (int'(v) <= hi);
   endfunction
endpackage

// File: rtl/ipi_rr_arb.sv
module ipi_rr_arb #(
   parameter int N   = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] gidx,
   output logic          gany
);
   logic [IW-1:0] ptr;

   always_comb begin
      grant = '0;
      gidx  = '0;
      gany  = 1'b0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = (int'(ptr) + k) % N;
         if (req[idx] && !gany) begin
            gany       = 1'b1;
            gidx       = IW'(idx);
            grant[idx] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr <= '0;
      else if (gany)   ptr <= (int'(gidx) == N-1) ? '0 : gidx + 1'b1;
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)) else $error("two grants");              // R9
   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0) |-> gany) else $error("request left idle");  // R9
endmodule

// File: rtl/ipi_lo_fifo.sv
module ipi_lo_fifo #(
   parameter int VW    = 8,
   parameter int DEPTH = 4,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [VW-1:0] din,
   output logic [VW-1:0] head,
   output logic          full,
   output logic          empty
);
   logic [VW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0] count;

   generate
      if (DEPTH > 1 && (DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CW'(DEPTH))) else $error("queue overflow"); // R5
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (count != '0)) else $error("queue underflow");        // R6
endmodule

// File: rtl/ipi_rx_slot.sv
module ipi_rx_slot #(
   parameter int VW       = 8,
   parameter int LQ_DEPTH = 4,
   parameter int VEC_LO   = 251,
   parameter int VEC_HI   = 255
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_hi,
   input  logic          push_lo,
   input  logic [VW-1:0] push_vec,
   input  logic          ack,
   output logic          hi_room,
   output logic          lo_room,
   output logic          irq,
   output logic [VW-1:0] irq_vec
);
   logic          hi_v;
   logic [VW-1:0] hi_vec;
   logic [VW-1:0] q_head;
   logic          q_full, q_empty, q_pop;

   assign q_pop = ack && !hi_v && !q_empty;

   ipi_lo_fifo #(.VW(VW), .DEPTH(LQ_DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_lo),
      .pop   (q_pop),
      .din   (push_vec),
      .head  (q_head),
      .full  (q_full),
      .empty (q_empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_v   <= 1'b0;
         hi_vec <= '0;
      end else if (push_hi) begin
         hi_v   <= 1'b1;
         hi_vec <= push_vec;
      end else if (ack && hi_v) begin
         hi_v   <= 1'b0;
      end
   end

   assign hi_room = !hi_v;
   assign lo_room = !q_full;
   assign irq     = hi_v || !q_empty;
   assign irq_vec = hi_v ? hi_vec : (q_empty ? '0 : q_head);

   AST_HI_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      push_hi |-> !hi_v) else $error("urgent slot overwritten");   // R4
   AST_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_v && !ack) |=> (hi_v && $stable(hi_vec))) else $error("urgent lost"); // R4
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq) else $error("irq dropped without ack"); // R8
   AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (int'(irq_vec) >= VEC_LO && int'(irq_vec) <= VEC_HI))
      else $error("bad vector offered");                           // R2
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
   import ipi_pkg::*;
#(
   parameter int NCORE    = 4,
   parameter int LQ_DEPTH = 4,
   parameter int VEC_LO   = IPI_VEC_LO,
   parameter int VEC_HI   = IPI_VEC_HI,
   localparam int VW      = VEC_W,
   localparam int IDW     = (NCORE > 1) ? $clog2(NCORE) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NCORE-1:0]    snd_valid,
   input  logic [NCORE*IDW-1:0] snd_dest,
   input  logic [NCORE*VW-1:0] snd_vec,
   input  logic [NCORE-1:0]    snd_hi,
   output logic [NCORE-1:0]    snd_accept,
   output logic [NCORE-1:0]    snd_busy,
   output logic [NCORE-1:0]    snd_reject,
   output logic [NCORE-1:0]    irq,
   output logic [NCORE*VW-1:0] irq_vec,
   input  logic [NCORE-1:0]    irq_ack
);
   initial begin
      assert (NCORE >= 2) else $error("NCORE must be at least 2");
      assert (LQ_DEPTH >= 1) else $error("LQ_DEPTH must be at least 1");
      assert (VEC_LO <= VEC_HI && VEC_HI < (1 << VW)) else $error("bad vector window");
   end

   logic [NCORE-1:0] well_formed, eligible, grant;
   logic [NCORE-1:0] hi_room, lo_room, push_hi, push_lo;
   logic [IDW-1:0]   gidx, g_dest;
   logic [VW-1:0]    g_vec;
   logic             gany, g_hi, g_room;

   // sender-side screening
   generate
      for (genvar i = 0; i < NCORE; i++) begin : g_screen
         assign well_formed[i] = vec_in_window(snd_vec[i*VW +: VW], VEC_LO, VEC_HI)
                              && (int'(snd_dest[i*IDW +: IDW]) < NCORE);
         assign eligible[i]    = snd_valid[i] && well_formed[i];
         assign snd_reject[i]  = snd_valid[i] && !well_formed[i];
      end
   endgenerate

   ipi_rr_arb #(.N(NCORE)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (eligible),
      .grant (grant),
      .gidx  (gidx),
      .gany  (gany)
   );

   // shared request path
   assign g_dest = snd_dest[gidx*IDW +: IDW];
   assign g_vec  = snd_vec[gidx*VW +: VW];
   assign g_hi   = snd_hi[gidx];
   assign g_room = g_hi ? hi_room[g_dest] : lo_room[g_dest];

   generate
      for (genvar i = 0; i < NCORE; i++) begin : g_resp
         assign snd_accept[i] = grant[i] && g_room;
         assign snd_busy[i]   = eligible[i] && !(grant[i] && g_room);
      end
   endgenerate

   generate
      for (genvar d = 0; d < NCORE; d++) begin : g_rx
         assign push_hi[d] = gany && g_room && g_hi  && (int'(g_dest) == d);
         assign push_lo[d] = gany && g_room && !g_hi && (int'(g_dest) == d);

         ipi_rx_slot #(.VW(VW), .LQ_DEPTH(LQ_DEPTH),
                       .VEC_LO(VEC_LO), .VEC_HI(VEC_HI)) u_rx (
            .clk      (clk),
            .rst_n    (rst_n),
            .push_hi  (push_hi[d]),
            .push_lo  (push_lo[d]),
            .push_vec (g_vec),
            .ack      (irq_ack[d]),
            .hi_room  (hi_room[d]),
            .lo_room  (lo_room[d]),
            .irq      (irq[d]),
            .irq_vec  (irq_vec[d*VW +: VW])
         );

         AST_ACCEPT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
            (push_hi[d] || push_lo[d]) |=> irq[d]) else $error("accepted but no irq"); // R3
      end

      for (genvar i = 0; i < NCORE; i++) begin : g_chk
         AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
            snd_valid[i] |-> ($countones({snd_accept[i], snd_busy[i], snd_reject[i]}) == 1))
            else $error("response not exclusive");                 // R1
         AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !snd_valid[i] |-> !(snd_accept[i] || snd_busy[i] || snd_reject[i]))
            else $error("response without request");               // R1
      end
   endgenerate

   AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(snd_accept) <= 1) else $error("two accepts");     // R9
endmodule

// File: tb/ipi_ctrl_bench.sv
module ipi_ctrl_bench;
   localparam int N   = 4;
   localparam int IDW = 2;
   localparam int VW  = 8;

   typedef enum logic [1:0] {E_ACC = 2'd0, E_BUSY = 2'd1, E_REJ = 2'd2} resp_e;
   typedef struct packed {
      logic [1:0] src;
      logic [1:0] dest;
      logic [7:0] vec;
      logic       hi;
      resp_e      exp;
   } post_t;

   localparam int NPOST = 11;
   localparam post_t TBL [NPOST] = '{
      '{2'd0, 2'd2, 8'd251, 1'b0, E_ACC },  // R5 queue 1
      '{2'd1, 2'd2, 8'd252, 1'b0, E_ACC },  // R5 queue 2
      '{2'd3, 2'd2, 8'd250, 1'b1, E_REJ },  // R2 below window
      '{2'd0, 2'd2, 8'd253, 1'b1, E_ACC },  // R3 urgent slot
      '{2'd1, 2'd2, 8'd254, 1'b1, E_BUSY},  // R4 slot full
      '{2'd3, 2'd2, 8'd255, 1'b0, E_ACC },  // R5 queue 3
      '{2'd0, 2'd2, 8'd251, 1'b0, E_ACC },  // R5 queue 4
      '{2'd1, 2'd2, 8'd252, 1'b0, E_BUSY},  // R5 queue full
      '{2'd2, 2'd0, 8'd0,   1'b0, E_REJ },  // R2 vector 0
      '{2'd2, 2'd3, 8'd255, 1'b1, E_ACC },  // R3 other recipient
      '{2'd2, 2'd1, 8'd9,   1'b1, E_REJ }   // R2 low vector
   };

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [N-1:0]        snd_valid = '0;
   logic [N*IDW-1:0]    snd_dest = '0;
   logic [N*VW-1:0]     snd_vec = '0;
   logic [N-1:0]        snd_hi = '0;
   logic [N-1:0]        snd_accept, snd_busy, snd_reject, irq;
   logic [N*VW-1:0]     irq_vec;
   logic [N-1:0]        irq_ack = '0;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   ipi_ctrl #(.NCORE(N), .LQ_DEPTH(4)) u_ipi_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .snd_valid  (snd_valid),
      .snd_dest   (snd_dest),
      .snd_vec    (snd_vec),
      .snd_hi     (snd_hi),
      .snd_accept (snd_accept),
      .snd_busy   (snd_busy),
      .snd_reject (snd_reject),
      .irq        (irq),
      .irq_vec    (irq_vec),
      .irq_ack    (irq_ack)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      snd_valid = '0;
      irq_ack = '0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Checks the offered vector at recipient d, then acknowledges it for one cycle.
   task automatic take(input int d, input logic [7:0] v, input string req);
      check({req, " irq"}, 32'(irq[d]), 32'd1);
      check({req, " vec"}, 32'(irq_vec[d*VW +: VW]), 32'(v));
      irq_ack[d] = 1'b1;
      @(negedge clk);
      irq_ack[d] = 1'b0;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R10 reset state
      check("R10 irq", 32'(irq), 32'd0);
      check("R10 vec", irq_vec, 32'd0);

      // table walk: one sender active per cycle
      for (int k = 0; k < NPOST; k++) begin
         post_t p;
         logic [2:0] got;
         p = TBL[k];
         snd_valid = '0;
         snd_valid[p.src] = 1'b1;
         snd_dest[p.src*IDW +: IDW] = p.dest;
         snd_vec[p.src*VW +: VW]    = p.vec;
         snd_hi[p.src]              = p.hi;
         #1;
         got = {snd_reject[p.src], snd_busy[p.src], snd_accept[p.src]};
         check($sformatf("R1 post %0d", k), 32'(got), 32'(3'b001 << p.exp));
         @(negedge clk);
      end
      snd_valid = '0;
      @(negedge clk);

      // R3 recipient 3 sees its urgent request; R2 recipients 0 and 1 see nothing
      check("R3 irq3", 32'(irq[3]), 32'd1);
      check("R3 vec3", 32'(irq_vec[3*VW +: VW]), 32'd255);
      check("R2 irq0/1 quiet", 32'(irq[1:0]), 32'd0);

      // R7/R4: urgent 253 first, then R6 arrival order
      take(2, 8'd253, "R7 urgent first (R4 kept)");
      take(2, 8'd251, "R6 queue 0");
      take(2, 8'd252, "R6 queue 1");
      take(2, 8'd255, "R6 queue 2");
      take(2, 8'd251, "R6 queue 3");
      check("R8 irq2 low", 32'(irq[2]), 32'd0);
      check("R8 vec2 zero", 32'(irq_vec[2*VW +: VW]), 32'd0);
      // R8 ack with nothing pending has no effect
      irq_ack[2] = 1'b1;
      @(negedge clk);
      irq_ack[2] = 1'b0;
      check("R8 idle ack", 32'(irq[2]), 32'd0);
      take(3, 8'd255, "R8 recipient 3");
      check("R8 irq3 low", 32'(irq[3]), 32'd0);

      // R9 round robin: all senders post low class to recipient 0
      do_reset();
      for (int i = 0; i < N; i++) begin
         snd_dest[i*IDW +: IDW] = 2'd0;
         snd_vec[i*VW +: VW]    = 8'(251 + i);
         snd_hi[i]              = 1'b0;
      end
      snd_valid = '1;
      for (int c = 0; c < N; c++) begin
         #1;
         check($sformatf("R9 accept c%0d", c), 32'(snd_accept), 32'(4'b0001 << c));
         check($sformatf("R9 busy c%0d", c), 32'(snd_busy), 32'(~(4'b0001 << c) & 4'hF));
         @(negedge clk);
      end
      #1;
      check("R5 all busy when full", 32'(snd_busy), 32'hF);
      check("R9 none accepted", 32'(snd_accept), 32'd0);
      @(negedge clk);
      snd_valid = '0;
      @(negedge clk);
      for (int i = 0; i < N; i++) take(0, 8'(251 + i), "R9 winner order");
      check("R8 irq0 low", 32'(irq[0]), 32'd0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule